// File: doc/BRIEF.md
# Presence-Detect EEPROM Target

This block is a synthesizable two-wire (I2C) target that behaves like a 256-byte serial presence-detect memory on a memory module. It watches a bus clock input and a data input, and it answers through a single drive-low output. This suits an open-drain line: the block either pulls the data line low or leaves it released. Both bus lines are sampled with the system clock through synchronizers. Start and stop conditions are found as data-line edges while the bus clock is high.

The 7-bit target address is a fixed upper nibble followed by three strap inputs. The block takes byte writes and multi-byte writes. It also serves a random read: a dummy write sets the word address, then a repeated start begins the read. Sequential reads then continue from that point. The word pointer advances by one, modulo the array size, after every byte read or written. The contents come out of reset from a parameter vector.

Writes are filtered in two ways. A high write-protect input blocks every write. When a build option is set, the lower half of the array (the module maker's region) is also read-only. Blocked writes are still acknowledged, so the bus master sees a normal transfer.

Top module: `spd_eeprom_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {DEV_HI, strap_i[2:0]}, with DEV_HI = 4'b1010 by default and strap_i[0] as the address LSB. For any other address it gives no acknowledge and keeps SDA released until the next START.
- R2: In a write transfer, the target pulls SDA low during the ninth clock of the address byte, of the word-address byte and of each data byte. A permitted data byte is stored at the current word address.
- R3: After a write-direction address and a word address, a repeated START with a read-direction address (LSB = 1) returns the byte at that word address, MSB first. The target drives each data bit while SCL is low.
- R4: The word pointer advances by one after every byte read or written, and wraps from the last address to address 0.
- R5: While wp_i is high, address, word and data bytes are still acknowledged, but the array is left unchanged.
- R6: With MAKER_LOCK = 1, writes to the lower half of the array (word addresses 0 to DEPTH/2-1) are acknowledged but ignored. The upper half stays writable.
- R7: After reset, every array byte i equals INIT[8*i+7:8*i], and sda_drive_low_o is 0.
- R8: A STOP or a repeated START in the middle of a byte stops the transfer. The partial byte is not written, SDA is released, and a repeated START begins a new address phase.
- R9: When the master does not acknowledge a read byte, the target releases SDA and stays quiet until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_drive_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 3 | Board straps forming the low three address bits |
| wp_i | input | 1 | Active-high write protect for the whole array |

## Verification
The bench builds the block with MAKER_LOCK = 1 and a non-trivial INIT pattern computed in the bench. This places the maker/customer boundary and reset contents within reach of readback. Multi-byte writes and reads that start at address 0xFE cross both the wrap from 0xFF to 0x00 and the locked region in one transfer. The bench uses strap value 3'b101 so that wrong-strap and wrong-nibble addresses can both be probed. Two-stage synchronizers are kept at their default, with bus phases several system clocks long.

// File: rtl/spd_pkg.sv
package spd_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WORD,
      ST_WORD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RD_ACK
   } spd_state_e;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spd_line_monitor.sv
module spd_line_monitor #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_lvl
);
   logic scl_s, sda_s, scl_q, sda_q;

   spd_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   spd_sync #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_lvl   = sda_s;
endmodule

// File: rtl/spd_protocol_fsm.sv
module spd_protocol_fsm
   import spd_pkg::*;
#(
   parameter int         AW     = 8,
   parameter logic [3:0] DEV_HI = 4'b1010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic          sda_in,
   input  logic [2:0]    strap_i,
   input  logic [7:0]    rd_data,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic [AW-1:0] rd_addr,
   output logic          sda_low
);
   localparam logic [AW-1:0] PTR_ONE  = AW'(1);
   localparam logic [3:0]    BIT_LAST = 4'd8;

   spd_state_e    state;
   logic [3:0]    cnt;
   logic [7:0]    sh_in;
   logic [7:0]    sh_out;
   logic [AW-1:0] ptr;
   logic          rw;
   logic          mnack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sh_in   <= '0;
         sh_out  <= '0;
         ptr     <= '0;
         rw      <= 1'b0;
         mnack   <= 1'b1;
         sda_low <= 1'b0;
         wr_req  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_req <= 1'b0;
         if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
         end else if (start_det) begin
            state   <= ST_DEV;
            cnt     <= '0;
            sda_low <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_WORD, ST_WDATA: begin
                  if (scl_rise && cnt < BIT_LAST) begin
                     sh_in <= {sh_in[6:0], sda_in};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == BIT_LAST) begin
                     cnt <= '0;
                     if (state == ST_DEV) begin
                        if (sh_in[7:1] == {DEV_HI, strap_i}) begin
                           rw      <= sh_in[0];
                           state   <= ST_DEV_ACK;
                           sda_low <= 1'b1;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_WORD) begin
                        ptr     <= sh_in[AW-1:0];
                        state   <= ST_WORD_ACK;
                        sda_low <= 1'b1;
                     end else begin
                        wr_req  <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= sh_in;
                        ptr     <= ptr + PTR_ONE;
                        state   <= ST_WDATA_ACK;
                        sda_low <= 1'b1;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        sh_out  <= rd_data;
                        sda_low <= ~rd_data[7];
                        state   <= ST_RDATA;
                     end else begin
                        sda_low <= 1'b0;
                        state   <= ST_WORD;
                     end
                  end
               end
               ST_WORD_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     state   <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise && cnt < BIT_LAST) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == BIT_LAST) begin
                        sda_low <= 1'b0;
                        ptr     <= ptr + PTR_ONE;
                        cnt     <= '0;
                        state   <= ST_RD_ACK;
                     end else begin
                        sh_out  <= {sh_out[6:0], 1'b0};
                        sda_low <= ~sh_out[6];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mnack <= sda_in;
                  end else if (scl_fall) begin
                     if (!mnack) begin
                        sh_out  <= rd_data;
                        sda_low <= ~rd_data[7];
                        state   <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_addr = ptr;

   // R1 / R9: an idle target never holds the data line
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_low);

   // R8: a stop condition drops the transfer and frees the line
   p_stop_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_low));

   // R8: a (repeated) start always opens a fresh address phase
   p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (state == ST_DEV && cnt == 4'd0));

   // R2: every acknowledge slot the target owns pulls the line low
   p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK || state == ST_WORD_ACK || state == ST_WDATA_ACK) |-> sda_low);

   // R4: the pointer has moved one past the byte just handed to the array
   p_wr_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> ptr == wr_addr + PTR_ONE);

   // R9: the master's acknowledge slot is never driven by the target
   p_rdack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RD_ACK |-> !sda_low);
endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
   parameter int                   DEPTH      = 256,
   parameter int                   AW         = 8,
   parameter bit                   MAKER_LOCK = 1'b0,
   parameter logic [8*DEPTH-1:0]   INIT       = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wp_i,
   input  logic          wr_req,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] mem [DEPTH];
   logic       region_ok;
   logic       wr_commit;

   generate
      if (MAKER_LOCK) begin : g_locked
         assign region_ok = wr_addr[AW-1];
      end else begin : g_open
         assign region_ok = 1'b1;
      end
   endgenerate

   assign wr_commit = wr_req & ~wp_i & region_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[8*i +: 8];
      end else if (wr_commit) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   // R5: a protected write leaves the addressed byte as it was
   p_wp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wp_i) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));

   // R2: an unprotected write into the customer half lands
   p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wp_i && wr_addr[AW-1]) |=> mem[$past(wr_addr)] == $past(wr_data));

   generate
      if (MAKER_LOCK) begin : g_lock_chk
         // R6: maker half is read-only in the locked variant
         p_maker_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_req && !wr_addr[AW-1]) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
      end
   endgenerate
endmodule

// File: rtl/spd_eeprom_target.sv
module spd_eeprom_target #(
   parameter int                 DEPTH       = 256,
   parameter logic [3:0]         DEV_HI      = 4'b1010,
   parameter int                 SYNC_STAGES = 2,
   parameter bit                 MAKER_LOCK  = 1'b0,
   parameter logic [8*DEPTH-1:0] INIT        = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_drive_low_o,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (AW > 8) begin : g_bad_aw
         $error("DEPTH must fit a one-byte word address");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic          scl_rise, scl_fall, start_det, stop_det, sda_lvl;
   logic          wr_req;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [7:0]    wr_data, rd_data;

   spd_line_monitor #(.STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl));

   spd_protocol_fsm #(.AW(AW), .DEV_HI(DEV_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_in(sda_lvl),
      .strap_i(strap_i), .rd_data(rd_data), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .sda_low(sda_drive_low_o));

   spd_byte_store #(.DEPTH(DEPTH), .AW(AW), .MAKER_LOCK(MAKER_LOCK), .INIT(INIT)) u_store (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data));
endmodule

// File: tb/spd_eeprom_target_tb.sv
`timescale 1ns/1ps
module spd_eeprom_target_tb;
   localparam int Q = 6;
   localparam logic [2:0] STRAP = 3'b101;

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) ^ (i >> 3));
   endfunction

   function automatic logic [2047:0] build_init();
      logic [2047:0] v;
      for (int i = 0; i < 256; i++) v[8*i +: 8] = pat(i);
      return v;
   endfunction

   localparam logic [2047:0] TB_INIT = build_init();

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic drive;
   logic sda_line;
   logic quiet = 1'b0;
   int   checks = 0;
   int   errors = 0;
   logic [7:0] ref_mem [256];

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~drive;

   spd_eeprom_target #(.DEPTH(256), .DEV_HI(4'b1010), .SYNC_STAGES(2),
                       .MAKER_LOCK(1'b1), .INIT(TB_INIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_drive_low_o(drive), .strap_i(STRAP), .wp_i(wp));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock reference: whenever the model says the target must be silent
   always @(negedge clk) begin
      if (rst_n && quiet) chk(!drive, "R1/R9 line must be released", int'(drive), 0);
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_c();
      quiet = 1'b0;
      sda_m = 1'b1; wait_n(Q);
      scl_m = 1'b1; wait_n(Q);
      sda_m = 1'b0; wait_n(Q);
      scl_m = 1'b0;
   endtask

   task automatic stop_c();
      quiet = 1'b0;
      sda_m = 1'b0; wait_n(Q);
      scl_m = 1'b1; wait_n(Q);
      sda_m = 1'b1; wait_n(Q);
      quiet = 1'b1;
   endtask

   task automatic wbit(input logic b);
      wait_n(Q);
      sda_m = b; quiet = 1'b1;
      wait_n(Q);
      scl_m = 1'b1;
      wait_n(2*Q);
      quiet = 1'b0; scl_m = 1'b0;
   endtask

   task automatic rbit(output logic v);
      sda_m = 1'b1;
      wait_n(2*Q);
      scl_m = 1'b1;
      wait_n(Q);
      v = sda_line;
      wait_n(Q);
      scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      logic v;
      for (int i = 7; i >= 0; i--) wbit(b[i]);
      rbit(v);
      ack = !v;
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         rbit(v);
         b[i] = v;
      end
      wbit(!give_ack);
   endtask

   function automatic logic [7:0] dev(input logic rd);
      return {4'b1010, STRAP, rd};
   endfunction

   task automatic wr_seq(input logic [7:0] waddr, input logic [7:0] d0, input int n, input string req);
      bit ack;
      start_c();
      send_byte(dev(1'b0), ack); chk(ack, {req, " address ack"}, int'(ack), 1);
      send_byte(waddr, ack);     chk(ack, {req, " word ack"}, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] a;
         a = 8'(waddr + k);
         send_byte(8'(d0 + k), ack);
         chk(ack, {req, " data ack"}, int'(ack), 1);
         if (!wp && a[7]) ref_mem[a] = 8'(d0 + k);
      end
      stop_c();
   endtask

   task automatic rd_seq(input logic [7:0] waddr, input int n, input string req);
      bit ack;
      logic [7:0] got;
      start_c();
      send_byte(dev(1'b0), ack); chk(ack, {req, " address ack"}, int'(ack), 1);
      send_byte(waddr, ack);     chk(ack, {req, " word ack"}, int'(ack), 1);
      start_c();
      send_byte(dev(1'b1), ack); chk(ack, {req, " read address ack"}, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         logic [7:0] a;
         a = 8'(waddr + k);
         recv_byte(got, k < n - 1);
         chk(got == ref_mem[a], {req, " read data"}, int'(got), int'(ref_mem[a]));
      end
      stop_c();
   endtask

   initial begin
      bit ack;
      logic [7:0] got;
      for (int i = 0; i < 256; i++) ref_mem[i] = pat(i);
      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      quiet = 1'b1;
      // R7: released after reset, contents from INIT
      chk(!drive, "R7 reset release", int'(drive), 0);
      rd_seq(8'h00, 2, "R7");
      rd_seq(8'hC3, 1, "R7");

      // R2 / R3: byte write then random read
      wr_seq(8'h90, 8'hA5, 1, "R2");
      rd_seq(8'h90, 1, "R3");

      // R1: wrong strap and wrong upper nibble get no acknowledge
      start_c();
      send_byte({4'b1010, 3'b100, 1'b0}, ack);
      chk(!ack, "R1 wrong strap nack", int'(ack), 0);
      for (int i = 0; i < 9; i++) wbit(1'b1);
      stop_c();
      start_c();
      send_byte({4'b0101, STRAP, 1'b1}, ack);
      chk(!ack, "R1 wrong nibble nack", int'(ack), 0);
      stop_c();

      // R4 / R6: multi-byte write across 0xFF -> 0x00, lower half locked
      wr_seq(8'hFE, 8'h30, 4, "R4");
      rd_seq(8'hFE, 4, "R4");

      // R6: boundary 0x7F locked, 0x80 writable
      wr_seq(8'h7F, 8'h60, 2, "R6");
      rd_seq(8'h7F, 2, "R6");
      wr_seq(8'h10, 8'h77, 1, "R6");
      rd_seq(8'h10, 1, "R6");

      // R5: protected writes are acknowledged and dropped
      wp = 1'b1;
      wr_seq(8'hA0, 8'h11, 2, "R5");
      wp = 1'b0;
      rd_seq(8'hA0, 2, "R5");

      // R8: stop in the middle of a data byte
      start_c();
      send_byte(dev(1'b0), ack); chk(ack, "R8 address ack", int'(ack), 1);
      send_byte(8'hB0, ack);     chk(ack, "R8 word ack", int'(ack), 1);
      for (int i = 0; i < 4; i++) wbit(1'b0);
      stop_c();
      wait_n(Q);
      chk(!drive, "R8 released after stop", int'(drive), 0);
      rd_seq(8'hB0, 1, "R8");

      // R8 / R3: repeated start mid-byte opens a read at the set pointer
      start_c();
      send_byte(dev(1'b0), ack); chk(ack, "R8 address ack", int'(ack), 1);
      send_byte(8'hB1, ack);     chk(ack, "R8 word ack", int'(ack), 1);
      for (int i = 0; i < 5; i++) wbit(1'b0);
      start_c();
      send_byte(dev(1'b1), ack); chk(ack, "R8 restart read ack", int'(ack), 1);
      recv_byte(got, 1'b0);
      chk(got == ref_mem[8'hB1], "R8 partial byte not written", int'(got), int'(ref_mem[8'hB1]));
      // R9: after the master's nack the target stays silent (per-clock check)
      quiet = 1'b1;
      wait_n(4*Q);
      stop_c();
      wait_n(4*Q);
      chk(!drive, "R9 quiet after nack", int'(drive), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule